// File: doc/BRIEF.md
# Receive Zero-Pattern Bit Error Counter

This block sits directly behind the receive descrambler of a link running block-based framing. Each received block header carries a field in which the link partner announces the mode of the block that follows. The block tracks that announcement. When the partner announces the zero-pattern test, the descrambled stream of the following block goes to an error counter instead of the normal block decoder. Because the partner transmits all zeroes in that mode, every 1 bit that arrives is counted as a bit error.

A second counter records how many bits were examined, so that software or a neighbouring block can divide the two values and get the bit error ratio. Reconfiguration is automatic: the header field alone decides the route, and no local setting is involved. Both counters clear when the partner starts a new test run, and whenever link status changes. Both counters saturate at their maximum value and never wrap.

Top module: `ber_rx_monitor`

## Requirements
- R1: The header field `rx_next_mode` (MODE_W bits, code 1 = zero-pattern test, any other code = normal) is taken only in a cycle with `rx_sob` high. The word of that cycle and every word after it, up to the next `rx_sob`, belong to a block whose mode is the one taken at the previous `rx_sob`. `route_test` is 1 exactly while the current word belongs to a test block, and 0 otherwise (normal decoder).
- R2: After a synchronous active-low reset, `err_count` and `bit_count` are 0, `route_test` is 0, and the previously announced mode is treated as normal.
- R3: In each clock edge where `rx_valid` is high and `route_test` is 1, `err_count` grows by the number of 1 bits in `rx_word`. The count appears in the following cycle. Invalid words and words of normal blocks leave `err_count` unchanged.
- R4: Under the same condition, `bit_count` grows by DATA_W.
- R5: Both counters clear in the cycle after an `rx_sob` whose header code is 1 when the code taken at the previous `rx_sob` was not 1. After reset, the previous code counts as not 1.
- R6: A test header that follows another test header does not clear the counters, so counts accumulate over consecutive test blocks.
- R7: Any change of `link_up`, rising or falling, clears both counters in the next cycle. A clear of either kind takes precedence over counting the word presented in the same cycle, so that word is not counted.
- R8: `err_count` stops at 2^ERR_W-1 and stays there until a clear.
- R9: `bit_count` stops at 2^BIT_W-1 and stays there until a clear, even when the last step overshoots.
- R10: Changes of `rx_next_mode` in cycles without `rx_sob` have no effect on routing or on clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_word | input | DATA_W | Descrambled data word |
| rx_valid | input | 1 | rx_word holds a data word this cycle |
| rx_sob | input | 1 | First word of a block; header field is present |
| rx_next_mode | input | MODE_W | Partner's announced mode for the next block |
| link_up | input | 1 | Link status |
| route_test | output | 1 | 1 = current word goes to the error counter, 0 = to the normal decoder |
| err_count | output | ERR_W | Saturating count of received 1 bits in test blocks |
| bit_count | output | BIT_W | Saturating count of bits checked in test blocks |

## Verification
The bench targets the one-block delay. A design that switches at the announcing header instead of the header after it would count the words of a normal block and would miss the first test block. The bench also runs back-to-back test headers: a design that clears on every test header, rather than only on the change into test, would lose the counts it had accumulated. Link toggles are made in the same cycle as a valid all-ones word, which exposes a counter that lets the count win over the clear. Long runs of all-ones words drive both narrowed counters into saturation, where a wrapping counter would drop back to a small value. The bench also changes the header field in cycles without a start-of-block flag, to show that such changes neither reroute the stream nor clear the counters.

// File: rtl/ber_pkg.sv
// Package: shared route encoding and default mode code for the receive
// BER counter. Assumes the header mode field is at most 8 bits wide.
package ber_pkg;
    typedef enum logic {
        ROUTE_DECODER = 1'b0,
        ROUTE_COUNTER = 1'b1
    } route_e;

    localparam int unsigned ZERO_TEST_CODE = 1;
endpackage

// File: rtl/ber_mode_tracker.sv
// Mode tracker: takes the partner's next-mode field at each start of block.
// It applies that mode one block later, and raises a clear request when the
// field enters the test code or when link status changes.
// Assumes the header field is only meaningful in cycles with sob_i high.
module ber_mode_tracker #(
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned TEST_CODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sob_i,
    input  logic [MODE_W-1:0] next_mode_i,
    input  logic              link_i,
    output ber_pkg::route_e   route_o,
    output logic              clear_o
);
    localparam logic [MODE_W-1:0] TEST = MODE_W'(TEST_CODE);

    logic [MODE_W-1:0] ann_q;
    logic              cur_test_q;
    logic              link_q;
    logic              ann_is_test;
    logic              use_test;
    logic              hdr_clear;
    logic              link_clear;

    // Decode the pending announcement and pick this word's route.
    always_comb begin
        ann_is_test = (ann_q == TEST);
        use_test    = sob_i ? ann_is_test : cur_test_q;
        route_o     = use_test ? ber_pkg::ROUTE_COUNTER : ber_pkg::ROUTE_DECODER;
    end

    // Form the clear request from header entry into test or a link change.
    always_comb begin
        hdr_clear  = sob_i && (next_mode_i == TEST) && !ann_is_test;
        link_clear = (link_i != link_q);
        clear_o    = hdr_clear || link_clear;
    end

    // Register the announcement, the active block mode and the link status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ann_q      <= '0;
            cur_test_q <= 1'b0;
            link_q     <= 1'b0;
        end else begin
            link_q <= link_i;
            if (sob_i) begin
                cur_test_q <= ann_is_test;
                ann_q      <= next_mode_i;
            end
        end
    end

    // R10
    hdr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sob_i |=> ($stable(ann_q) && $stable(cur_test_q)));

    // R1
    block_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sob_i && next_mode_i == TEST) |=> (ann_q == TEST));
endmodule

// File: rtl/ber_popcount.sv
// Popcount: counts the 1 bits of one data word in a single cycle.
// Purely combinational; assumes OUT_W is wide enough to hold DATA_W.
module ber_popcount #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned OUT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [OUT_W-1:0]  ones_o
);
    logic [OUT_W-1:0] partial [DATA_W+1];

    // Build the running sum as a chain of bit additions.
    assign partial[0] = '0;
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign partial[b+1] = partial[b] + OUT_W'(word_i[b]);
    end

    assign ones_o = partial[DATA_W];
endmodule

// File: rtl/ber_sat_counter.sv
// Saturating accumulator: adds inc_i when en_i is high and clears on clr_i.
// Clear wins over the add. Stops at the all-ones value instead of wrapping.
// Assumes CNT_W is greater than INC_W.
module ber_sat_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] next_val;

    // Wide add, then clamp at the maximum when it carries out.
    always_comb begin
        sum      = {1'b0, cnt_q} + (CNT_W + 1)'(inc_i);
        next_val = sum[CNT_W] ? MAX : sum[CNT_W-1:0];
    end

    // Hold, clear or accumulate the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= next_val;
        end
    end

    assign cnt_o = cnt_q;

    // R8 R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_q == MAX) |=> (cnt_q == MAX));

    // R5 R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R3
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/ber_rx_monitor.sv
// Receive BER counter: routes descrambled words to the normal decoder or to
// the error counter, following the partner's header one block ahead. In
// test blocks it counts 1 bits as errors and counts the bits it examined.
// Assumes rx_sob marks the first word of a block and carries the header field.
module ber_rx_monitor #(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned ERR_W     = 32,
    parameter int unsigned BIT_W     = 48,
    parameter int unsigned TEST_CODE = ber_pkg::ZERO_TEST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_valid,
    input  logic              rx_sob,
    input  logic [MODE_W-1:0] rx_next_mode,
    input  logic              link_up,
    output logic              route_test,
    output logic [ERR_W-1:0]  err_count,
    output logic [BIT_W-1:0]  bit_count
);
    localparam int unsigned POP_W = $clog2(DATA_W + 1);
    localparam logic [POP_W-1:0] WORD_BITS = POP_W'(DATA_W);

    ber_pkg::route_e  route;
    logic             clear;
    logic             count_en;
    logic [POP_W-1:0] ones;

    ber_mode_tracker #(
        .MODE_W    (MODE_W),
        .TEST_CODE (TEST_CODE)
    ) i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .sob_i       (rx_sob),
        .next_mode_i (rx_next_mode),
        .link_i      (link_up),
        .route_o     (route),
        .clear_o     (clear)
    );

    ber_popcount #(
        .DATA_W (DATA_W),
        .OUT_W  (POP_W)
    ) i_pop (
        .word_i (rx_word),
        .ones_o (ones)
    );

    // Count only valid words that are routed to the error counter.
    always_comb begin
        route_test = (route == ber_pkg::ROUTE_COUNTER);
        count_en   = rx_valid && route_test;
    end

    ber_sat_counter #(
        .CNT_W (ERR_W),
        .INC_W (POP_W)
    ) i_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear),
        .en_i  (count_en),
        .inc_i (ones),
        .cnt_o (err_count)
    );

    ber_sat_counter #(
        .CNT_W (BIT_W),
        .INC_W (POP_W)
    ) i_bit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear),
        .en_i  (count_en),
        .inc_i (WORD_BITS),
        .cnt_o (bit_count)
    );

    // R3
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(err_count));

    // R4
    bit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(bit_count));

    // R7
    link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != $past(link_up)) |=> (err_count == '0 && bit_count == '0));
endmodule

// File: tb/test_ber_rx_monitor.sv
`timescale 1ns/1ps
module test_ber_rx_monitor;
    localparam int unsigned DW = 16;
    localparam int unsigned MW = 2;
    localparam int unsigned EW = 10;
    localparam int unsigned BW = 12;
    localparam int unsigned EMAX = (1 << EW) - 1;
    localparam int unsigned BMAX = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] rx_word = '0;
    logic          rx_valid = 1'b0;
    logic          rx_sob = 1'b0;
    logic [MW-1:0] rx_next_mode = '0;
    logic          link_up = 1'b0;
    logic          route_test;
    logic [EW-1:0] err_count;
    logic [BW-1:0] bit_count;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model state
    int  m_ann = 0;
    bit  m_cur = 1'b0;
    bit  m_link = 1'b0;
    int  m_err = 0;
    int  m_bit = 0;

    ber_rx_monitor #(
        .DATA_W (DW), .MODE_W (MW), .ERR_W (EW), .BIT_W (BW), .TEST_CODE (1)
    ) i_ber_rx_monitor (
        .clk (clk), .rst_n (rst_n), .rx_word (rx_word), .rx_valid (rx_valid),
        .rx_sob (rx_sob), .rx_next_mode (rx_next_mode), .link_up (link_up),
        .route_test (route_test), .err_count (err_count), .bit_count (bit_count)
    );

    always #10 clk = ~clk;

    function automatic int ones_of(logic [DW-1:0] w);
        int n = 0;
        for (int i = 0; i < DW; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic int clamp(int v, int mx);
        return (v > mx) ? mx : v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus with route and count checks against the model.
    task automatic step(logic [DW-1:0] w, bit v, bit s, int mode, bit lk, string tag);
        bit r;
        bit clr;
        @(negedge clk);
        rx_word = w; rx_valid = v; rx_sob = s;
        rx_next_mode = MW'(mode); link_up = lk;
        #1;
        r = s ? (m_ann == 1) : m_cur;
        check(tag, "route_test", int'(route_test), int'(r));
        clr = (s && mode == 1 && m_ann != 1) || (lk != m_link);
        @(posedge clk);
        if (clr) begin
            m_err = 0; m_bit = 0;
        end else if (v && r) begin
            m_err = clamp(m_err + ones_of(w), EMAX);
            m_bit = clamp(m_bit + DW, BMAX);
        end
        if (s) begin
            m_cur = (m_ann == 1);
            m_ann = mode;
        end
        m_link = lk;
        #1;
        check(tag, "err_count", int'(err_count), m_err);
        check(tag, "bit_count", int'(bit_count), m_bit);
    endtask

    // A block of n valid words with a given header; word pattern by kind.
    task automatic block(int mode, int n, int kind, bit lk, string tag);
        logic [DW-1:0] w;
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: w = '0;
                1: w = '1;
                default: w = DW'($urandom) & DW'($urandom) & DW'($urandom);
            endcase
            step(w, 1'b1, (i == 0), (i == 0) ? mode : 0, lk, tag);
        end
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_0b1e));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", "err_count after reset", int'(err_count), 0);
        check("R2", "bit_count after reset", int'(bit_count), 0);
        check("R2", "route after reset", int'(route_test), 0);
        rst_n = 1'b1;
        // link comes up: R7 clear on rising edge
        step('0, 1'b0, 1'b0, 0, 1'b1, "R7");
        // First block announces test; its own words stay normal (R1).
        block(1, 4, 1, 1'b1, "R1");
        // Block announced as test: counted (R3, R4).
        block(1, 6, 2, 1'b1, "R3");
        block(1, 6, 1, 1'b1, "R6");
        check("R4", "bits over two test blocks", int'(bit_count), 12 * DW);
        // Announce normal; next block still test, then normal.
        block(0, 5, 1, 1'b1, "R4");
        block(0, 5, 1, 1'b1, "R1");
        check("R1", "normal block not counted", int'(bit_count), 17 * DW);
        // Invalid words inside a test block are ignored (R3).
        block(1, 2, 0, 1'b1, "R5");
        check("R5", "entry into test clears", int'(err_count), 0);
        block(1, 2, 1, 1'b1, "R3");
        step('1, 1'b0, 1'b0, 0, 1'b1, "R3");
        step('1, 1'b0, 1'b0, 3, 1'b1, "R10");
        step('1, 1'b1, 1'b0, 1, 1'b1, "R10");
        // Header changes off sob: no effect (R10).
        step('1, 1'b1, 1'b0, 0, 1'b1, "R10");
        // Link drop with a valid word in a test block: clear wins (R7).
        step('1, 1'b1, 1'b0, 0, 1'b0, "R7");
        check("R7", "clear beats count", int'(err_count), 0);
        step('1, 1'b1, 1'b0, 0, 1'b0, "R7");
        step('1, 1'b1, 1'b0, 0, 1'b1, "R7");
        // Saturation of both counters (R8, R9).
        for (int k = 0; k < 40; k++) block(1, 8, 1, 1'b1, "R8");
        check("R8", "err saturated", int'(err_count), EMAX);
        check("R9", "bit saturated", int'(bit_count), BMAX);
        // Random traffic.
        for (int k = 0; k < 400; k++) begin
            int md;
            bit lk;
            md = (($urandom % 4) != 0) ? 1 : int'($urandom % 4);
            lk = (($urandom % 40) == 0) ? ~m_link : m_link;
            for (int i = 0; i < 8; i++) begin
                step(DW'($urandom) & DW'($urandom) & DW'($urandom),
                     bit'($urandom % 2), (i == 0),
                     (i == 0) ? md : int'($urandom % 4),
                     (i == 0) ? lk : m_link, "R3");
            end
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule